// File: doc/BRIEF.md
# Logarithmic Code Converter

This block translates between an 8-bit logarithmic code and a plain unsigned integer, and works in both directions at the same time. The upper nibble of a code selects a segment and the lower nibble selects a step inside it. Each segment starts where the previous one ends, and its step size is twice the step size of the segment below. Small magnitudes are therefore exact, and large magnitudes are kept with about four significant bits.

The decode side turns a code into its integer value with one shift and one add. The encode side takes a 32-bit integer and returns the largest code whose value does not exceed that integer, so it truncates. To do this it counts leading zeros, makes a first exponent guess from the leading-one position, corrects that guess by at most one segment in either direction, and then extracts the mantissa. Integers at or above the value of the top code saturate to that code.

A parameter chooses whether both results leave through one output register or as pure combinational logic. Typical uses are compressing counters, histogram bins or timer values into a byte, and expanding them again.

Top module: `logcode_conv`

## Requirements
- R1: Code bits [7:4] hold the exponent e and bits [3:0] hold the mantissa m. The decoded value equals m·2^e + (2^e − 1)·16.
- R2: Decoded values rise strictly as the code rises. Code 0x00 decodes to 0 and code 0xFF decodes to 1015792.
- R3: An input value below 16 is returned unchanged as the code, with exponent 0.
- R4: For inputs below 1015792, the encoder returns the largest code whose decoded value is less than or equal to the input. Any remainder is truncated.
- R5: Every input of 1015792 or more, including values wider than 20 bits up to 0xFFFFFFFF, encodes to 0xFF.
- R6: Encoding the decoded value of any of the 256 codes returns that same code.
- R7: With the default PIPE=1, both outputs change one clock after their inputs, and an active-low reset drives both outputs to zero. With PIPE=0 the paths are combinational.
- R8: At each segment boundary e in 1..15, the value (2^e − 1)·16 encodes to e<<4. One less than that value encodes to ((e − 1)<<4) | 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| code_in | input | 8 | Code to be expanded |
| value_out | output | 20 | Integer value of code_in |
| value_in | input | 32 | Integer to be compressed |
| code_out | output | 8 | Largest code not above value_in |

## Verification
The assertions check several rules at every clock: small inputs pass through unchanged, saturating inputs give the all-ones code, codes with exponent 0 decode to their mantissa, and the top code decodes to its fixed maximum. Inside the encoder, other assertions check on every evaluation that the leading-zero count lands on a set bit and that the extracted mantissa fits in four bits. Some properties can only be shown by the bench's sweeps over all codes and over many values: that decoding is strictly monotonic, that encode after decode returns the original code, that the largest-code rule holds just below and at every segment boundary, and that the one-cycle latency and reset values are correct.

// File: rtl/logcode_pkg.sv
package logcode_pkg;

    // Start value of segment e: (2^e - 1) scaled by the mantissa range.
    function automatic logic [63:0] seg_base(input int unsigned e, input int unsigned man_w);
        return ((64'd1 << e) - 64'd1) << man_w;
    endfunction

    // Integer represented by exponent e and mantissa m.
    function automatic logic [63:0] code_value(input int unsigned e, input int unsigned m,
                                               input int unsigned man_w);
        return (64'(m) << e) + seg_base(e, man_w);
    endfunction

endpackage

// File: rtl/lc_lzc.sv
module lc_lzc #(
    parameter int W = 32,
    localparam int LEVELS = $clog2(W),
    localparam int CNT_W  = LEVELS + 1
) (
    input  logic [W-1:0]     din,
    output logic [CNT_W-1:0] zeros
);

    logic [W-1:0]     x_s [0:LEVELS];
    logic [CNT_W-1:0] n_s [0:LEVELS];

    assign x_s[0] = din;
    assign n_s[0] = CNT_W'(W);

    // Halving search: test the upper part at each shift distance.
    for (genvar g = 0; g < LEVELS; g++) begin : g_step
        localparam int SH = 1 << (LEVELS - 1 - g);
        logic [W-1:0] upper;
        assign upper      = x_s[g] >> SH;
        assign x_s[g + 1] = (upper != '0) ? upper : x_s[g];
        assign n_s[g + 1] = (upper != '0) ? (n_s[g] - CNT_W'(SH)) : n_s[g];
    end

    assign zeros = n_s[LEVELS] - CNT_W'(x_s[LEVELS]);

    always_comb begin
        if (din != '0) begin
            AST_LZC_MSB: assert (din[W - 1 - int'(zeros)] == 1'b1); // R4
        end else begin
            AST_LZC_ZERO: assert (zeros == CNT_W'(W)); // R3
        end
    end

endmodule

// File: rtl/lc_decode.sv
module lc_decode #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    localparam int CODE_W = EXP_W + MAN_W,
    localparam int VAL_W  = MAN_W + (2 ** EXP_W)
) (
    input  logic [CODE_W-1:0] code,
    output logic [VAL_W-1:0]  value
);

    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;

    assign ex    = code[CODE_W-1:MAN_W];
    assign mn    = code[MAN_W-1:0];
    assign value = VAL_W'(logcode_pkg::code_value(32'(ex), 32'(mn), MAN_W));

endmodule

// File: rtl/lc_encode.sv
module lc_encode #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int IN_W  = 32,
    localparam int CODE_W = EXP_W + MAN_W,
    localparam int EMAX   = (2 ** EXP_W) - 1,
    localparam int CNT_W  = $clog2(IN_W) + 1
) (
    input  logic [IN_W-1:0]   din,
    output logic [CODE_W-1:0] code
);

    localparam logic [63:0] SMALL = 64'(2 ** MAN_W);
    localparam logic [63:0] SAT   = logcode_pkg::code_value(EMAX, (2 ** MAN_W) - 1, MAN_W);

    logic [CNT_W-1:0] zeros;
    logic [63:0]      v64;
    logic [63:0]      raw;
    int               msb;
    int               e_est;
    int               e_lo;
    int               e_fin;

    lc_lzc #(.W(IN_W)) u_lzc (
        .din   (din),
        .zeros (zeros)
    );

    assign v64 = 64'(din);

    always_comb begin
        msb   = IN_W - 1 - int'(zeros);
        e_est = 0;
        if (msb >= MAN_W + 1) begin
            e_est = (msb - MAN_W > EMAX) ? EMAX : msb - MAN_W;
        end
        // Step down one segment if the guess starts above the value.
        e_lo = e_est;
        if (e_lo > 0 && logcode_pkg::seg_base(e_lo, MAN_W) > v64) begin
            e_lo = e_lo - 1;
        end
        // Step up one segment if the value reaches the next segment.
        e_fin = e_lo;
        if (e_lo < EMAX && v64 >= logcode_pkg::seg_base(e_lo + 1, MAN_W)) begin
            e_fin = e_lo + 1;
        end
        raw = (v64 - logcode_pkg::seg_base(e_fin, MAN_W)) >> e_fin;

        if (v64 >= SAT) begin
            code = '1;
        end else if (v64 < SMALL) begin
            code = CODE_W'(v64);
        end else begin
            code = {EXP_W'(e_fin), MAN_W'(raw)};
        end
    end

    always_comb begin
        if (v64 >= SMALL && v64 < SAT) begin
            AST_ENC_MANT_FIT: assert (raw < SMALL); // R4
        end
    end

endmodule

// File: rtl/logcode_conv.sv
module logcode_conv #(
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int IN_W  = 32,
    parameter int PIPE  = 1,
    localparam int CODE_W = EXP_W + MAN_W,
    localparam int VAL_W  = MAN_W + (2 ** EXP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic [VAL_W-1:0]  value_out,
    input  logic [IN_W-1:0]   value_in,
    output logic [CODE_W-1:0] code_out
);

    localparam int          EMAX  = (2 ** EXP_W) - 1;
    localparam logic [63:0] SAT   = logcode_pkg::code_value(EMAX, (2 ** MAN_W) - 1, MAN_W);
    localparam logic [63:0] SMALL = 64'(2 ** MAN_W);

    logic [VAL_W-1:0]  dec_val;
    logic [CODE_W-1:0] enc_code;

    lc_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
        .code  (code_in),
        .value (dec_val)
    );

    lc_encode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .IN_W(IN_W)) u_enc (
        .din  (value_in),
        .code (enc_code)
    );

    if (PIPE != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value_out <= '0;
                code_out  <= '0;
            end else begin
                value_out <= dec_val;
                code_out  <= enc_code;
            end
        end

        AST_SMALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (64'(value_in) < SMALL) |=> (code_out == CODE_W'($past(value_in)))); // R3

        AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (64'(value_in) >= SAT) |=> (code_out == '1)); // R5

        AST_DEC_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
            (code_in[CODE_W-1:MAN_W] == '0) |=>
            (value_out == VAL_W'($past(code_in[MAN_W-1:0])))); // R1

        AST_DEC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            (code_in == '1) |=> (64'(value_out) == SAT)); // R2
    end else begin : g_comb
        assign value_out = dec_val;
        assign code_out  = enc_code;
    end

endmodule

// File: tb/logcode_conv_tb.sv
module logcode_conv_tb;

    localparam longint SATV = 1015792;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  code_in = 8'h5A;
    logic [31:0] value_in = 32'd1000;
    logic [19:0] value_out;
    logic [7:0]  code_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    logcode_conv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_in   (code_in),
        .value_out (value_out),
        .value_in  (value_in),
        .code_out  (code_out)
    );

    function automatic longint ref_dec(input int c);
        longint p;
        p = 1;
        for (int i = 0; i < c / 16; i++) p = p * 2;
        return longint'(c % 16) * p + (p - 1) * 16;
    endfunction

    function automatic int ref_enc(input longint v);
        for (int c = 255; c >= 0; c--) begin
            if (ref_dec(c) <= v) return c;
        end
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enc_check(input longint v, input string tag);
        int e;
        @(negedge clk);
        value_in = 32'(v);
        @(negedge clk);
        e = ref_enc(v);
        chk(code_out == 8'(e), tag, longint'(code_out), longint'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint prev;
        repeat (3) @(negedge clk);
        // R7: reset holds both outputs at zero
        chk(value_out == 20'd0, "R7 reset value_out", longint'(value_out), 0);
        chk(code_out == 8'd0, "R7 reset code_out", longint'(code_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(value_out == 20'(ref_dec(8'h5A)), "R1 after reset", longint'(value_out), ref_dec(8'h5A));

        // R7: one-cycle latency
        code_in = 8'h23;
        #2;
        chk(value_out == 20'(ref_dec(8'h5A)), "R7 before edge", longint'(value_out), ref_dec(8'h5A));
        @(negedge clk);
        chk(value_out == 20'(ref_dec(8'h23)), "R7 after edge", longint'(value_out), ref_dec(8'h23));

        // Sweep every code: R1 value, R2 monotonic, R6 round trip
        prev = -1;
        for (int c = 0; c < 256; c++) begin
            code_in  = 8'(c);
            value_in = 32'(ref_dec(c));
            @(negedge clk);
            chk(longint'(value_out) == ref_dec(c), "R1 decode", longint'(value_out), ref_dec(c));
            chk(code_out == 8'(c), "R6 round trip", longint'(code_out), longint'(c));
            chk(longint'(value_out) > prev, "R2 monotonic", longint'(value_out), prev + 1);
            prev = longint'(value_out);
        end
        chk(prev == SATV, "R2 top code", prev, SATV);

        // Exhaustive low range: R3 below 16, R4 above
        for (int v = 0; v < 4096; v++) begin
            value_in = 32'(v);
            @(negedge clk);
            if (v < 16)
                chk(code_out == 8'(v), "R3 small pass", longint'(code_out), longint'(v));
            else
                chk(code_out == 8'(ref_enc(v)), "R4 largest code", longint'(code_out), longint'(ref_enc(v)));
        end

        // Sparse sweep of the rest of the range
        for (longint v = 4096; v < 1100000; v += 997) enc_check(v, "R4 sparse");

        // R8: segment boundaries
        for (int e = 1; e < 16; e++) begin
            longint b;
            b = ref_dec(e * 16);
            enc_check(b, "R8 boundary");
            chk(code_out == 8'(e * 16), "R8 boundary code", longint'(code_out), longint'(e * 16));
            enc_check(b - 1, "R8 below boundary");
            chk(code_out == 8'((e - 1) * 16 + 15), "R8 below code", longint'(code_out),
                longint'((e - 1) * 16 + 15));
        end

        // R5: saturation
        enc_check(SATV - 1, "R5 just below");
        enc_check(SATV, "R5 at limit");
        enc_check(1048575, "R5 20-bit max");
        enc_check(1048576, "R5 above 20 bits");
        @(negedge clk);
        value_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(code_out == 8'hFF, "R5 all ones input", longint'(code_out), 255);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule